// File: doc/BRIEF.md
# Parallel-Prefix FSM State Evaluator

This block runs a small deterministic pattern-matching state machine over a whole window of bytes in a single cycle. Each byte in the window is first turned into a transition map. A transition map is a vector that lists the next state for every possible current state. Because a map does not depend on what came before, all maps are formed at once. A Kogge-Stone prefix network then composes adjacent maps. Position k ends up holding the combined effect of bytes 0 through k. Applying each prefix to the state carried in from the previous window gives the state after every byte. The result is the same as stepping the machine one byte at a time, from byte 0 upward.

The pattern is a parameter. With P pattern bytes the machine has P+1 states. State n means the last n bytes seen equal the first n pattern bytes. State P means the whole pattern has just been completed. The state after the last byte of a window is kept in a register and seeds the next window, so a match may span window boundaries. Each accepted window produces registered per-position states, per-position match bits and the new carry state one cycle later.

Top module: `prefix_fsm_scan`

## Requirements
- R1: After a synchronous reset, `valid_out`, `carry_out`, every `state_out` field and every `match_out` bit are 0.
- R2: States are encoded as the count of pattern bytes matched, 0 to P. From state n < P, the byte equal to pattern byte n moves to n+1. Byte 0 of the window is `data_in[7:0]` and is consumed first. The state after byte k is output in `state_out[k*SW +: SW]`, where SW = clog2(P+1).
- R3: A byte that breaks a partial match goes to state 1 if it equals pattern byte 0, and to state 0 otherwise. For example, "aab" with pattern "abcd" ends in state 2.
- R4: From the accepting state P, the next byte gives state 1 if it equals pattern byte 0, and state 0 otherwise.
- R5: Every per-position state equals the state that a serial byte-at-a-time machine reaches after consuming that byte, starting from the carried state.
- R6: `match_out[k]` is 1 exactly when the state after byte k equals P.
- R7: The state after the last byte of an accepted window is the start state of the next accepted window, so a pattern spanning two windows is matched in the second one.
- R8: A cycle with `valid_in` low leaves `carry_out` and `state_out` unchanged and gives `valid_out` low on the next cycle.
- R9: Results for a window sampled with `valid_in` high appear with `valid_out` high on the following cycle.
- R10: While `valid_out` is high, `carry_out` equals the state of the last position of the window.
- R11: Every output state field is less than P+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Window on `data_in` is to be consumed this cycle |
| data_in | input | NUM_BYTES*8 | Byte window, byte 0 in the low bits |
| valid_out | output | 1 | Outputs hold the result of a window |
| state_out | output | NUM_BYTES*SW | State after each byte, position k in field k |
| match_out | output | NUM_BYTES | Pattern completed at byte k |
| carry_out | output | SW | State carried into the next window |

## Verification
The bench goes after overlapping partial matches such as "aab" and "abab". A design that resets to 0 on every mismatch, instead of restarting on the first pattern byte, would miss the match that follows. It sends patterns split across two windows with an idle cycle between them. A carry that is lost, reset, or overwritten by the idle cycle shows up as a missed match in the second window. Back-to-back completions and the byte after an accept are covered too. They expose a composition order swapped between earlier and later maps, or a wrong distance at one prefix level. Either fault corrupts states only at some positions, which the per-position comparison against a serial model reports.

// File: rtl/fsm_scan_pkg.sv
package fsm_scan_pkg;
   localparam int unsigned SYM_W = 8;
   typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/byte_map_gen.sv
// Turns one byte into a transition map: field s holds the next state from state s.
module byte_map_gen
   import fsm_scan_pkg::*;
#(
   parameter int unsigned PAT_LEN          = 4,
   parameter logic [PAT_LEN*SYM_W-1:0] PATTERN = "abcd",
   parameter bit          RESTART_ON_FIRST = 1'b1,
   parameter int unsigned NUM_ST           = PAT_LEN + 1,
   parameter int unsigned SW               = $clog2(NUM_ST)
) (
   input  sym_t                        sym_i,
   output logic [NUM_ST-1:0][SW-1:0]   map_o
);
   localparam sym_t         FIRST_SYM = PATTERN[(PAT_LEN-1)*SYM_W +: SYM_W];
   localparam logic [SW-1:0] ST_ONE   = SW'(1);

   logic [SW-1:0] restart_st;

   // Where a broken partial match lands: variant chosen by parameter
   generate
      if (RESTART_ON_FIRST) begin : g_restart
         assign restart_st = (sym_i == FIRST_SYM) ? ST_ONE : '0;
      end else begin : g_clear
         assign restart_st = '0;
      end
   endgenerate

   generate
      for (genvar s = 0; s < NUM_ST; s++) begin : g_field
         if (s < PAT_LEN) begin : g_prog
            localparam sym_t          EXPECT = PATTERN[(PAT_LEN-1-s)*SYM_W +: SYM_W];
            localparam logic [SW-1:0] ADV    = SW'(s + 1);
            assign map_o[s] = (sym_i == EXPECT) ? ADV : restart_st;
         end else begin : g_accept
            assign map_o[s] = restart_st;
         end
      end
   endgenerate
endmodule

// File: rtl/map_compose.sv
// Composition of two segment maps: the later map is applied to the earlier map's exit state.
module map_compose #(
   parameter int unsigned NUM_ST = 5,
   parameter int unsigned SW     = $clog2(NUM_ST)
) (
   input  logic [NUM_ST-1:0][SW-1:0] early_i,
   input  logic [NUM_ST-1:0][SW-1:0] late_i,
   output logic [NUM_ST-1:0][SW-1:0] comb_o
);
   generate
      for (genvar i = 0; i < NUM_ST; i++) begin : g_ent
         assign comb_o[i] = late_i[early_i[i]];
      end
   endgenerate
endmodule

// File: rtl/kogge_stone_scan.sv
// Inclusive prefix composition over NUM_POS maps in log2(NUM_POS) levels.
module kogge_stone_scan #(
   parameter int unsigned NUM_POS = 8,
   parameter int unsigned NUM_ST  = 5,
   parameter int unsigned SW      = $clog2(NUM_ST)
) (
   input  logic [NUM_POS-1:0][NUM_ST-1:0][SW-1:0] maps_i,
   output logic [NUM_POS-1:0][NUM_ST-1:0][SW-1:0] pref_o
);
   localparam int unsigned LVLS = $clog2(NUM_POS);

   logic [NUM_POS-1:0][NUM_ST-1:0][SW-1:0] stage [LVLS+1];

   assign stage[0] = maps_i;

   generate
      for (genvar l = 0; l < LVLS; l++) begin : g_lvl
         localparam int unsigned DIST = 1 << l;
         for (genvar k = 0; k < NUM_POS; k++) begin : g_pos
            if (k >= DIST) begin : g_join
               map_compose #(.NUM_ST(NUM_ST), .SW(SW)) u_comp (
                  .early_i (stage[l][k-DIST]),
                  .late_i  (stage[l][k]),
                  .comb_o  (stage[l+1][k])
               );
            end else begin : g_pass
               // equivalent to composing with the identity map
               assign stage[l+1][k] = stage[l][k];
            end
         end
      end
   endgenerate

   assign pref_o = stage[LVLS];
endmodule

// File: rtl/prefix_fsm_scan.sv
module prefix_fsm_scan
   import fsm_scan_pkg::*;
#(
   parameter int unsigned NUM_BYTES        = 8,
   parameter int unsigned PAT_LEN          = 4,
   parameter logic [PAT_LEN*SYM_W-1:0] PATTERN = "abcd",
   parameter bit          RESTART_ON_FIRST = 1'b1,
   localparam int unsigned NUM_ST          = PAT_LEN + 1,
   localparam int unsigned SW              = $clog2(NUM_ST)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      valid_in,
   input  logic [NUM_BYTES*SYM_W-1:0] data_in,
   output logic                      valid_out,
   output logic [NUM_BYTES*SW-1:0]   state_out,
   output logic [NUM_BYTES-1:0]      match_out,
   output logic [SW-1:0]             carry_out
);
   localparam logic [SW-1:0] ACCEPT = SW'(PAT_LEN);

   generate
      if (NUM_BYTES < 2 || (NUM_BYTES & (NUM_BYTES - 1)) != 0) begin : g_bad_n
         $error("NUM_BYTES must be a power of two, at least 2");
      end
      if (PAT_LEN < 1) begin : g_bad_p
         $error("PAT_LEN must be at least 1");
      end
   endgenerate

   logic [NUM_BYTES-1:0][NUM_ST-1:0][SW-1:0] maps;
   logic [NUM_BYTES-1:0][NUM_ST-1:0][SW-1:0] prefix;
   logic [NUM_BYTES-1:0][SW-1:0]             st_next;
   logic [NUM_BYTES-1:0]                     hit_next;

   logic                          valid_q;
   logic [NUM_BYTES-1:0][SW-1:0]  state_q;
   logic [NUM_BYTES-1:0]          match_q;
   logic [SW-1:0]                 carry_q;

   generate
      for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
         byte_map_gen #(
            .PAT_LEN(PAT_LEN), .PATTERN(PATTERN),
            .RESTART_ON_FIRST(RESTART_ON_FIRST),
            .NUM_ST(NUM_ST), .SW(SW)
         ) u_map (
            .sym_i (data_in[k*SYM_W +: SYM_W]),
            .map_o (maps[k])
         );
         assign st_next[k]  = prefix[k][carry_q];
         assign hit_next[k] = (st_next[k] == ACCEPT);
      end
   endgenerate

   kogge_stone_scan #(.NUM_POS(NUM_BYTES), .NUM_ST(NUM_ST), .SW(SW)) u_scan (
      .maps_i (maps),
      .pref_o (prefix)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         state_q <= '0;
         match_q <= '0;
         carry_q <= '0;
      end else begin
         valid_q <= valid_in;
         if (valid_in) begin
            state_q <= st_next;
            match_q <= hit_next;
            carry_q <= st_next[NUM_BYTES-1];
         end
      end
   end

   assign valid_out = valid_q;
   assign state_out = state_q;
   assign match_out = match_q;
   assign carry_out = carry_q;

   // R9
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      valid_in |=> valid_out);
   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> !valid_out);
   // R8
   carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> $stable(carry_q));
   // R10
   carry_last_chk: assert property (@(posedge clk) disable iff (rst)
      valid_out |-> carry_q == state_q[NUM_BYTES-1]);

   generate
      for (genvar k = 0; k < NUM_BYTES; k++) begin : g_chk
         // R11
         state_range_chk: assert property (@(posedge clk) disable iff (rst)
            valid_out |-> state_q[k] <= ACCEPT);
         // R6
         match_flag_chk: assert property (@(posedge clk) disable iff (rst)
            valid_out |-> match_q[k] == (state_q[k] == ACCEPT));
      end
   endgenerate
endmodule

// File: tb/prefix_fsm_scan_test.sv
module prefix_fsm_scan_test;
   localparam int N  = 8;
   localparam int P  = 4;
   localparam int SW = 3;
   localparam logic [31:0] PAT = "abcd";

   logic           clk = 1'b0;
   logic           rst;
   logic           valid_in;
   logic [N*8-1:0] data_in;
   logic           valid_out;
   logic [N*SW-1:0] state_out;
   logic [N-1:0]   match_out;
   logic [SW-1:0]  carry_out;

   int checks = 0;
   int errors = 0;
   int exp_carry = 0;

   always #5 clk = ~clk;

   prefix_fsm_scan uut (
      .clk(clk), .rst(rst), .valid_in(valid_in), .data_in(data_in),
      .valid_out(valid_out), .state_out(state_out),
      .match_out(match_out), .carry_out(carry_out)
   );

   function automatic logic [7:0] pat_byte(int i);
      return PAT[(P-1-i)*8 +: 8];
   endfunction

   // serial reference: one byte at a time
   function automatic int ref_next(int s, logic [7:0] b);
      if (s < P && b == pat_byte(s)) return s + 1;
      if (b == pat_byte(0)) return 1;
      return 0;
   endfunction

   function automatic logic [N*8-1:0] pack(string s);
      logic [N*8-1:0] d = '0;
      for (int k = 0; k < N; k++) d[k*8 +: 8] = s[k];
      return d;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_window(logic [N*8-1:0] d, string req);
      int st [N];
      int s = exp_carry;
      bit st_ok = 1'b1;
      bit mt_ok = 1'b1;
      for (int k = 0; k < N; k++) begin
         s = ref_next(s, d[k*8 +: 8]);
         st[k] = s;
      end
      @(negedge clk);
      valid_in = 1'b1;
      data_in  = d;
      @(negedge clk);
      valid_in = 1'b0;
      check(valid_out == 1'b1, "R9", "valid_out", int'(valid_out), 1);
      for (int k = 0; k < N; k++) begin
         if (int'(state_out[k*SW +: SW]) != st[k]) begin
            st_ok = 1'b0;
            $display("FAIL %s state pos %0d: actual %0d expected %0d",
                     req, k, state_out[k*SW +: SW], st[k]);
         end
         if (match_out[k] != (st[k] == P)) begin
            mt_ok = 1'b0;
            $display("FAIL R6 match pos %0d: actual %0d expected %0d",
                     k, match_out[k], st[k] == P);
         end
      end
      checks += 2;
      if (!st_ok) errors++;
      if (!mt_ok) errors++;
      check(int'(carry_out) == st[N-1], "R10", "carry_out", int'(carry_out), st[N-1]);
      exp_carry = st[N-1];
   endtask

   task automatic idle_check();
      logic [N*SW-1:0] held = state_out;
      @(negedge clk);
      check(valid_out == 1'b0, "R8", "valid_out idle", int'(valid_out), 0);
      check(int'(carry_out) == exp_carry, "R8", "carry idle", int'(carry_out), exp_carry);
      check(state_out == held, "R8", "state_out idle", int'(state_out), int'(held));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [N*8-1:0] d;
      void'($urandom(32'd20240611));
      rst = 1'b1; valid_in = 1'b0; data_in = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(valid_out == 1'b0, "R1", "valid_out", int'(valid_out), 0);
      check(carry_out == '0, "R1", "carry_out", int'(carry_out), 0);
      check(state_out == '0, "R1", "state_out", int'(state_out), 0);
      check(match_out == '0, "R1", "match_out", int'(match_out), 0);
      rst = 1'b0;

      run_window(pack("abcdxxxx"), "R2");       // plain advance, state encoding
      run_window(pack("aabxabab"), "R3");       // restart on first pattern byte
      run_window(pack("abcdabcd"), "R4");       // back-to-back accept, 'a' after accept
      run_window(pack("abcdbxxx"), "R4");       // non-first byte after accept
      idle_check();
      run_window(pack("xxxxxxab"), "R7");       // split across windows
      idle_check();
      run_window(pack("cdxxxxxa"), "R7");       // completes at position 1
      run_window(pack("bcdabcda"), "R7");
      run_window(pack("zzzzzzzz"), "R5");

      for (int w = 0; w < 300; w++) begin
         for (int k = 0; k < N; k++) begin
            if ($urandom_range(0, 3) == 0) d[k*8 +: 8] = 8'($urandom_range(0, 255));
            else d[k*8 +: 8] = 8'("a") + 8'($urandom_range(0, 3));
         end
         run_window(d, "R5");
         if ((w % 37) == 0) idle_check();
      end

      // R11: a valid state field never exceeds the accepting state
      check(int'(carry_out) <= P, "R11", "carry range", int'(carry_out), P);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule